// File: doc/BRIEF.md
# Early Branch Target Checker

This block sits in the decode path of a multi-threaded core and inspects every instruction bundle on its way to rename. It uses the target that decode has already computed to settle direct unconditional branches before execution. When that target disagrees with the one fetch predicted, or when fetch predicted a jump on an instruction that does not transfer control at all, the block builds a redirect record for fetch. It also marks the younger instructions of the same thread in the bundle as squashed.

Each cycle up to `W` instruction slots arrive in age order, oldest in slot 0, and each slot carries its own thread id. The block has a delay-slot mode, chosen by a static input. In that mode a mispredicted branch either squashes right away or hands its redirect to the next instruction of its thread, which is the delay slot. A delay slot that arrives in a later bundle is still caught. Forwarded slots, squash marks, issue-ready flags and redirect records all appear one cycle after the bundle is presented. Three free-running counters keep totals of resolved branches, target mismatches and false-control predictions.

Top module: `early_br_check`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, every output is zero: no valid slot, no squash mark, no redirect and all counters at zero.
- R2: A live instruction is counted as a resolved branch only when its control, direct and unconditional flags are all set. A live instruction is one that is neither squashed nor acting as a delay slot. Indirect or conditional control instructions add nothing to `cnt_resolved`.
- R3: A resolved branch whose computed target differs from its predicted target adds one to `cnt_tgt_miss` and raises a redirect for its thread. The record has `redir_tgt_miss`=1 and `redir_pc` equal to the computed target. Outputs appear on the clock edge after the edge that samples the bundle.
- R4: The redirect taken bit is 1 exactly when the computed target differs from the instruction's PC plus `ISZ` (4 by default).
- R5: Once a redirect fires at a squash point, every later slot of the same thread in that bundle whose sequence number is greater than the squash point is marked squashed. Older slots, the firing slot and slots of other threads are left unmarked.
- R6: With delay-slot mode off, and also with it on when the branch was predicted taken and its conditional-delay-slot flag is set, a target mismatch redirects at once. The squash point (`redir_seq`) is the branch's own sequence number.
- R7: With delay-slot mode on and the exception of R6 absent, a target mismatch fires no redirect yet. The redirect fires when the next valid instruction of the same thread arrives, in the same bundle or a later one. Its squash point is the branch sequence number plus one, and that delay-slot instruction itself is not squashed.
- R8: An instruction predicted taken whose control flag is clear adds one to `cnt_ctrl_miss` and redirects at its own sequence number. The record has `redir_tgt_miss`=0, `redir_pc` equal to its PC plus `ISZ`, and taken bit 0.
- R9: A valid slot whose source-register count is zero is flagged in `out_issue_rdy`; other slots are not.
- R10: A thread gets at most one redirect per cycle, and the oldest triggering instruction wins. Younger same-thread instructions behind it are squashed and neither counted nor allowed to redirect.
- R11: The delay-slot instruction that releases a deferred redirect is not itself checked: it adds to no counter and cannot raise a redirect of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dslot_mode | input | 1 | Delay-slot mode enable (static) |
| in_vld | input | W | Slot valid |
| in_seq | input | W*SEQW | Per-slot sequence number |
| in_tid | input | W*TIDW | Per-slot thread id |
| in_pc | input | W*PCW | Per-slot instruction PC |
| in_ctrl | input | W | Slot is a control transfer |
| in_direct | input | W | Control transfer is direct |
| in_uncond | input | W | Control transfer is unconditional |
| in_pred_taken | input | W | Fetch predicted taken |
| in_pred_tgt | input | W*PCW | Fetch-predicted target |
| in_calc_tgt | input | W*PCW | Decode-computed target |
| in_cond_ds | input | W | Delay slot of this branch is conditional |
| in_nsrc | input | W*SRCW | Source-register count |
| out_vld | output | W | Forwarded slot valid |
| out_squashed | output | W | Forwarded slot is squashed |
| out_issue_rdy | output | W | Forwarded slot has no sources |
| redir_vld | output | T | Redirect record valid, per thread |
| redir_tgt_miss | output | T | 1: target mismatch, 0: false control |
| redir_seq | output | T*SEQW | Sequence number of last kept instruction |
| redir_pc | output | T*PCW | Corrected next PC |
| redir_taken | output | T | Corrected flow is taken |
| cnt_resolved | output | CNTW | Resolved-branch counter |
| cnt_tgt_miss | output | CNTW | Target-mismatch counter |
| cnt_ctrl_miss | output | CNTW | False-control counter |

## Verification
The hardest case to reach is a deferred redirect whose delay slot lands in the next bundle. It is hardest of all when that delay slot is itself a mispredicted branch, and younger same-thread instructions then follow it. Random bundles seldom put a deferring mismatch in the last live slot of a thread. Directed cycles therefore place the branch in the final slot, then supply a bundle that opens with a bad branch of the same thread followed by more of its instructions. The random phase then runs with the mode on and a biased mix of mismatching direct branches, so deferrals often straddle bundle boundaries.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    localparam int EBC_SEQW_DEF = 16;
    localparam int EBC_PCW_DEF  = 32;

    typedef enum logic {
        RK_FALSE_CTRL = 1'b0,
        RK_TGT_MISS   = 1'b1
    } redir_kind_e;
endpackage

// File: rtl/ebc_slot_eval.sv
module ebc_slot_eval #(
    parameter int PCW  = 32,
    parameter int SRCW = 2,
    parameter int ISZ  = 4
) (
    input  logic            is_ctrl,
    input  logic            is_direct,
    input  logic            is_uncond,
    input  logic            pred_taken,
    input  logic            cond_ds,
    input  logic [PCW-1:0]  pc,
    input  logic [PCW-1:0]  pred_tgt,
    input  logic [PCW-1:0]  calc_tgt,
    input  logic [SRCW-1:0] nsrc,
    output logic            chk_dir,
    output logic            tgt_bad,
    output logic            fake_ctrl,
    output logic            may_defer,
    output logic            no_src,
    output logic [PCW-1:0]  fix_pc,
    output logic            fix_taken
);
    logic [PCW-1:0] fall_pc;

    assign fall_pc = pc + PCW'(ISZ);

    always_comb begin
        chk_dir   = is_ctrl && is_direct && is_uncond;
        fake_ctrl = pred_taken && !is_ctrl;
        tgt_bad   = chk_dir && (calc_tgt != pred_tgt);
        may_defer = !(pred_taken && cond_ds);
        no_src    = (nsrc == '0);
        if (fake_ctrl) begin
            fix_pc    = fall_pc;
            fix_taken = 1'b0;
        end else begin
            fix_pc    = calc_tgt;
            fix_taken = (calc_tgt != fall_pc);
        end
    end
endmodule

// File: rtl/ebc_thread_scan.sv
module ebc_thread_scan #(
    parameter int W    = 4,
    parameter int SEQW = 16,
    parameter int PCW  = 32,
    parameter int TIDW = 1,
    parameter int TID  = 0,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]      vld,
    input  logic [W*SEQW-1:0] seq,
    input  logic [W*TIDW-1:0] tid,
    input  logic [W-1:0]      chk_dir,
    input  logic [W-1:0]      tgt_bad,
    input  logic [W-1:0]      fake_ctrl,
    input  logic [W-1:0]      may_defer,
    input  logic [W*PCW-1:0]  fix_pc,
    input  logic [W-1:0]      fix_taken,
    input  logic              ds_mode,
    input  logic              pend_vld_i,
    input  logic [SEQW-1:0]   pend_seq_i,
    input  logic [PCW-1:0]    pend_pc_i,
    input  logic              pend_taken_i,
    output logic [W-1:0]      kill,
    output logic              seen,
    output logic              fire,
    output logic              fire_kind,
    output logic [SEQW-1:0]   fire_seq,
    output logic [PCW-1:0]    fire_pc,
    output logic              fire_taken,
    output logic              pend_vld_o,
    output logic [SEQW-1:0]   pend_seq_o,
    output logic [PCW-1:0]    pend_pc_o,
    output logic              pend_taken_o,
    output logic [CW-1:0]     n_dir,
    output logic [CW-1:0]     n_miss,
    output logic [CW-1:0]     n_fake
);
    import ebc_pkg::*;

    logic            killed;
    logic [SEQW-1:0] cut;
    logic [SEQW-1:0] s_seq;

    always_comb begin
        killed       = 1'b0;
        cut          = '0;
        s_seq        = '0;
        kill         = '0;
        seen         = 1'b0;
        fire         = 1'b0;
        fire_kind    = RK_FALSE_CTRL;
        fire_seq     = '0;
        fire_pc      = '0;
        fire_taken   = 1'b0;
        pend_vld_o   = pend_vld_i;
        pend_seq_o   = pend_seq_i;
        pend_pc_o    = pend_pc_i;
        pend_taken_o = pend_taken_i;
        n_dir        = '0;
        n_miss       = '0;
        n_fake       = '0;
        for (int s = 0; s < W; s++) begin
            s_seq = seq[s*SEQW +: SEQW];
            if (vld[s] && (tid[s*TIDW +: TIDW] == TIDW'(TID))) begin
                seen = 1'b1;
                if (killed) begin
                    // flush only what is younger than the squash point
                    kill[s] = (s_seq > cut);
                end else if (pend_vld_o) begin
                    // delay slot arrived: release the held redirect
                    fire       = 1'b1;
                    fire_kind  = RK_TGT_MISS;
                    fire_seq   = pend_seq_o;
                    fire_pc    = pend_pc_o;
                    fire_taken = pend_taken_o;
                    cut        = pend_seq_o;
                    killed     = 1'b1;
                    pend_vld_o = 1'b0;
                end else begin
                    if (chk_dir[s]) n_dir = n_dir + CW'(1);
                    if (fake_ctrl[s]) begin
                        n_fake     = n_fake + CW'(1);
                        fire       = 1'b1;
                        fire_kind  = RK_FALSE_CTRL;
                        fire_seq   = s_seq;
                        fire_pc    = fix_pc[s*PCW +: PCW];
                        fire_taken = fix_taken[s];
                        cut        = s_seq;
                        killed     = 1'b1;
                    end else if (tgt_bad[s]) begin
                        n_miss = n_miss + CW'(1);
                        if (ds_mode && may_defer[s]) begin
                            pend_vld_o   = 1'b1;
                            pend_seq_o   = s_seq + SEQW'(1);
                            pend_pc_o    = fix_pc[s*PCW +: PCW];
                            pend_taken_o = fix_taken[s];
                        end else begin
                            fire       = 1'b1;
                            fire_kind  = RK_TGT_MISS;
                            fire_seq   = s_seq;
                            fire_pc    = fix_pc[s*PCW +: PCW];
                            fire_taken = fix_taken[s];
                            cut        = s_seq;
                            killed     = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/early_br_check.sv
module early_br_check #(
    parameter int W    = 4,
    parameter int T    = 2,
    parameter int SEQW = ebc_pkg::EBC_SEQW_DEF,
    parameter int PCW  = ebc_pkg::EBC_PCW_DEF,
    parameter int SRCW = 2,
    parameter int CNTW = 16,
    parameter int ISZ  = 4,
    localparam int TIDW = (T > 1) ? $clog2(T) : 1,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dslot_mode,
    input  logic [W-1:0]      in_vld,
    input  logic [W*SEQW-1:0] in_seq,
    input  logic [W*TIDW-1:0] in_tid,
    input  logic [W*PCW-1:0]  in_pc,
    input  logic [W-1:0]      in_ctrl,
    input  logic [W-1:0]      in_direct,
    input  logic [W-1:0]      in_uncond,
    input  logic [W-1:0]      in_pred_taken,
    input  logic [W*PCW-1:0]  in_pred_tgt,
    input  logic [W*PCW-1:0]  in_calc_tgt,
    input  logic [W-1:0]      in_cond_ds,
    input  logic [W*SRCW-1:0] in_nsrc,
    output logic [W-1:0]      out_vld,
    output logic [W-1:0]      out_squashed,
    output logic [W-1:0]      out_issue_rdy,
    output logic [T-1:0]      redir_vld,
    output logic [T-1:0]      redir_tgt_miss,
    output logic [T*SEQW-1:0] redir_seq,
    output logic [T*PCW-1:0]  redir_pc,
    output logic [T-1:0]      redir_taken,
    output logic [CNTW-1:0]   cnt_resolved,
    output logic [CNTW-1:0]   cnt_tgt_miss,
    output logic [CNTW-1:0]   cnt_ctrl_miss
);
    typedef struct packed {
        logic [W-1:0]      vld;
        logic [W-1:0]      sq;
        logic [W-1:0]      rdy;
        logic [T-1:0]      r_vld;
        logic [T-1:0]      r_miss;
        logic [T-1:0]      r_taken;
        logic [T*SEQW-1:0] r_seq;
        logic [T*PCW-1:0]  r_pc;
        logic [T-1:0]      p_vld;
        logic [T-1:0]      p_taken;
        logic [T*SEQW-1:0] p_seq;
        logic [T*PCW-1:0]  p_pc;
        logic [CNTW-1:0]   c_dir;
        logic [CNTW-1:0]   c_miss;
        logic [CNTW-1:0]   c_fake;
    } ebc_state_t;

    ebc_state_t state_d, state_q;

    // per-slot classification
    logic [W-1:0]     chk_dir, tgt_bad, fake_ctrl, may_defer, no_src, fix_taken;
    logic [W*PCW-1:0] fix_pc;

    for (genvar s = 0; s < W; s++) begin : g_slot
        ebc_slot_eval #(.PCW(PCW), .SRCW(SRCW), .ISZ(ISZ)) u_eval (
            .is_ctrl    (in_ctrl[s]),
            .is_direct  (in_direct[s]),
            .is_uncond  (in_uncond[s]),
            .pred_taken (in_pred_taken[s]),
            .cond_ds    (in_cond_ds[s]),
            .pc         (in_pc[s*PCW +: PCW]),
            .pred_tgt   (in_pred_tgt[s*PCW +: PCW]),
            .calc_tgt   (in_calc_tgt[s*PCW +: PCW]),
            .nsrc       (in_nsrc[s*SRCW +: SRCW]),
            .chk_dir    (chk_dir[s]),
            .tgt_bad    (tgt_bad[s]),
            .fake_ctrl  (fake_ctrl[s]),
            .may_defer  (may_defer[s]),
            .no_src     (no_src[s]),
            .fix_pc     (fix_pc[s*PCW +: PCW]),
            .fix_taken  (fix_taken[s])
        );

        AST_ZERO_SRC_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld[s] && (in_nsrc[s*SRCW +: SRCW] == '0)) |=> state_q.rdy[s]); // R9
    end

    // per-thread oldest-first scan
    logic [T-1:0][W-1:0]    kill_t;
    logic [T-1:0]           seen_t, fire_t, kind_t, ftk_t, pv_t, ptk_t;
    logic [T-1:0][SEQW-1:0] fseq_t, pseq_t;
    logic [T-1:0][PCW-1:0]  fpc_t, ppc_t;
    logic [T-1:0][CW-1:0]   ndir_t, nmiss_t, nfake_t;

    for (genvar t = 0; t < T; t++) begin : g_thr
        ebc_thread_scan #(.W(W), .SEQW(SEQW), .PCW(PCW), .TIDW(TIDW), .TID(t)) u_scan (
            .vld          (in_vld),
            .seq          (in_seq),
            .tid          (in_tid),
            .chk_dir      (chk_dir),
            .tgt_bad      (tgt_bad),
            .fake_ctrl    (fake_ctrl),
            .may_defer    (may_defer),
            .fix_pc       (fix_pc),
            .fix_taken    (fix_taken),
            .ds_mode      (dslot_mode),
            .pend_vld_i   (state_q.p_vld[t]),
            .pend_seq_i   (state_q.p_seq[t*SEQW +: SEQW]),
            .pend_pc_i    (state_q.p_pc[t*PCW +: PCW]),
            .pend_taken_i (state_q.p_taken[t]),
            .kill         (kill_t[t]),
            .seen         (seen_t[t]),
            .fire         (fire_t[t]),
            .fire_kind    (kind_t[t]),
            .fire_seq     (fseq_t[t]),
            .fire_pc      (fpc_t[t]),
            .fire_taken   (ftk_t[t]),
            .pend_vld_o   (pv_t[t]),
            .pend_seq_o   (pseq_t[t]),
            .pend_pc_o    (ppc_t[t]),
            .pend_taken_o (ptk_t[t]),
            .n_dir        (ndir_t[t]),
            .n_miss       (nmiss_t[t]),
            .n_fake       (nfake_t[t])
        );

        AST_DEFER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q.p_vld[t] && seen_t[t]) |=> (state_q.r_vld[t] && state_q.r_miss[t])); // R7
    end

    always_comb begin
        logic [W-1:0]    kill_any;
        logic [CNTW-1:0] add_dir, add_miss, add_fake;
        state_d  = state_q;
        kill_any = '0;
        add_dir  = '0;
        add_miss = '0;
        add_fake = '0;
        for (int t = 0; t < T; t++) begin
            kill_any = kill_any | kill_t[t];
            add_dir  = add_dir  + CNTW'(ndir_t[t]);
            add_miss = add_miss + CNTW'(nmiss_t[t]);
            add_fake = add_fake + CNTW'(nfake_t[t]);
            state_d.r_vld[t]                = fire_t[t];
            state_d.r_miss[t]               = kind_t[t];
            state_d.r_taken[t]              = ftk_t[t];
            state_d.r_seq[t*SEQW +: SEQW]   = fseq_t[t];
            state_d.r_pc[t*PCW +: PCW]      = fpc_t[t];
            state_d.p_vld[t]                = pv_t[t];
            state_d.p_taken[t]              = ptk_t[t];
            state_d.p_seq[t*SEQW +: SEQW]   = pseq_t[t];
            state_d.p_pc[t*PCW +: PCW]      = ppc_t[t];
        end
        state_d.vld    = in_vld;
        state_d.sq     = in_vld & kill_any;
        state_d.rdy    = in_vld & no_src;
        state_d.c_dir  = state_q.c_dir  + add_dir;
        state_d.c_miss = state_q.c_miss + add_miss;
        state_d.c_fake = state_q.c_fake + add_fake;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_vld        = state_q.vld;
    assign out_squashed   = state_q.sq;
    assign out_issue_rdy  = state_q.rdy;
    assign redir_vld      = state_q.r_vld;
    assign redir_tgt_miss = state_q.r_miss;
    assign redir_seq      = state_q.r_seq;
    assign redir_pc       = state_q.r_pc;
    assign redir_taken    = state_q.r_taken;
    assign cnt_resolved   = state_q.c_dir;
    assign cnt_tgt_miss   = state_q.c_miss;
    assign cnt_ctrl_miss  = state_q.c_fake;

    AST_SQUASH_HAS_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (|state_q.sq) |-> (|state_q.r_vld)); // R5
    AST_FAKE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.r_vld & ~state_q.r_miss & state_q.r_taken) == '0); // R8
    AST_MISS_WITH_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.c_miss != $past(state_q.c_miss)) |-> (state_q.c_dir != $past(state_q.c_dir))); // R3
endmodule

// File: tb/sim_early_br_check.sv
module sim_early_br_check;
    localparam int W = 4, T = 2, SEQW = 16, PCW = 32, SRCW = 2, CNTW = 16, ISZ = 4, TIDW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dslot_mode = 1'b0;
    logic [W-1:0]      in_vld = '0, in_ctrl = '0, in_direct = '0, in_uncond = '0;
    logic [W-1:0]      in_pred_taken = '0, in_cond_ds = '0;
    logic [W*SEQW-1:0] in_seq = '0;
    logic [W*TIDW-1:0] in_tid = '0;
    logic [W*PCW-1:0]  in_pc = '0, in_pred_tgt = '0, in_calc_tgt = '0;
    logic [W*SRCW-1:0] in_nsrc = '0;
    logic [W-1:0]      out_vld, out_squashed, out_issue_rdy;
    logic [T-1:0]      redir_vld, redir_tgt_miss, redir_taken;
    logic [T*SEQW-1:0] redir_seq;
    logic [T*PCW-1:0]  redir_pc;
    logic [CNTW-1:0]   cnt_resolved, cnt_tgt_miss, cnt_ctrl_miss;

    always #4 clk = ~clk;

    early_br_check #(.W(W), .T(T), .SEQW(SEQW), .PCW(PCW), .SRCW(SRCW), .CNTW(CNTW), .ISZ(ISZ)) u0 (
        .clk(clk), .rst_n(rst_n), .dslot_mode(dslot_mode),
        .in_vld(in_vld), .in_seq(in_seq), .in_tid(in_tid), .in_pc(in_pc),
        .in_ctrl(in_ctrl), .in_direct(in_direct), .in_uncond(in_uncond),
        .in_pred_taken(in_pred_taken), .in_pred_tgt(in_pred_tgt), .in_calc_tgt(in_calc_tgt),
        .in_cond_ds(in_cond_ds), .in_nsrc(in_nsrc),
        .out_vld(out_vld), .out_squashed(out_squashed), .out_issue_rdy(out_issue_rdy),
        .redir_vld(redir_vld), .redir_tgt_miss(redir_tgt_miss), .redir_seq(redir_seq),
        .redir_pc(redir_pc), .redir_taken(redir_taken),
        .cnt_resolved(cnt_resolved), .cnt_tgt_miss(cnt_tgt_miss), .cnt_ctrl_miss(cnt_ctrl_miss)
    );

    int checks = 0, errors = 0;

    // bench-side bundle
    bit           b_vld[W], b_ctrl[W], b_dir[W], b_unc[W], b_ptk[W], b_cds[W];
    int           b_tid[W], b_ns[W];
    logic [15:0]  b_seq[W];
    logic [31:0]  b_pc[W], b_pt[W], b_ct[W];
    logic [15:0]  seq_ctr = 16'd100;

    // reference model state
    bit           m_pv[T], m_ptk[T];
    logic [15:0]  m_ps[T];
    logic [31:0]  m_pp[T];
    int           m_cdir = 0, m_cmiss = 0, m_cfake = 0;

    // expected outputs
    logic [W-1:0] e_vld, e_sq, e_rdy;
    bit           e_rv[T], e_rm[T], e_rt[T];
    logic [15:0]  e_rs[T];
    logic [31:0]  e_rp[T];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_slots();
        for (int s = 0; s < W; s++) begin
            b_vld[s] = 0; b_ctrl[s] = 0; b_dir[s] = 0; b_unc[s] = 0; b_ptk[s] = 0;
            b_cds[s] = 0; b_tid[s] = 0; b_ns[s] = 1; b_seq[s] = '0;
            b_pc[s] = '0; b_pt[s] = '0; b_ct[s] = '0;
        end
    endtask

    // kind: 0 plain, 1 direct unconditional branch, 2 indirect, 3 direct conditional
    task automatic mk(input int s, input int tid, input int kind, input bit ptk, input bit cds,
                      input logic [31:0] coff, input bit bad, input int ns);
        b_vld[s] = 1; b_tid[s] = tid; b_seq[s] = seq_ctr; seq_ctr = seq_ctr + 16'd1;
        b_pc[s]  = 32'h0000_1000 + 32'(s * 64) + {$urandom % 256, 8'h00} * 32'd4;
        b_ctrl[s] = (kind != 0); b_dir[s] = (kind == 1 || kind == 3); b_unc[s] = (kind == 1 || kind == 2);
        b_ptk[s] = ptk; b_cds[s] = cds; b_ns[s] = ns;
        b_ct[s] = b_pc[s] + coff;
        b_pt[s] = bad ? b_ct[s] + 32'd8 : b_ct[s];
    endtask

    task automatic apply();
        for (int s = 0; s < W; s++) begin
            in_vld[s] = b_vld[s]; in_ctrl[s] = b_ctrl[s]; in_direct[s] = b_dir[s];
            in_uncond[s] = b_unc[s]; in_pred_taken[s] = b_ptk[s]; in_cond_ds[s] = b_cds[s];
            in_seq[s*SEQW +: SEQW] = b_seq[s];
            in_tid[s*TIDW +: TIDW] = TIDW'(b_tid[s]);
            in_pc[s*PCW +: PCW] = b_pc[s];
            in_pred_tgt[s*PCW +: PCW] = b_pt[s];
            in_calc_tgt[s*PCW +: PCW] = b_ct[s];
            in_nsrc[s*SRCW +: SRCW] = SRCW'(b_ns[s]);
        end
    endtask

    task automatic model_step(input bit ds);
        e_vld = '0; e_sq = '0; e_rdy = '0;
        for (int s = 0; s < W; s++) begin
            e_vld[s] = b_vld[s];
            e_rdy[s] = b_vld[s] && (b_ns[s] == 0);
        end
        for (int t = 0; t < T; t++) begin
            bit dead = 0;
            logic [15:0] cut = '0;
            e_rv[t] = 0; e_rm[t] = 0; e_rt[t] = 0; e_rs[t] = '0; e_rp[t] = '0;
            for (int s = 0; s < W; s++) begin
                if (b_vld[s] && b_tid[s] == t) begin
                    if (dead) begin
                        if (b_seq[s] > cut) e_sq[s] = 1;
                    end else if (m_pv[t]) begin
                        e_rv[t] = 1; e_rm[t] = 1; e_rs[t] = m_ps[t]; e_rp[t] = m_pp[t]; e_rt[t] = m_ptk[t];
                        cut = m_ps[t]; dead = 1; m_pv[t] = 0;
                    end else begin
                        bit isdir = b_ctrl[s] && b_dir[s] && b_unc[s];
                        if (isdir) m_cdir++;
                        if (b_ptk[s] && !b_ctrl[s]) begin
                            m_cfake++;
                            e_rv[t] = 1; e_rm[t] = 0; e_rs[t] = b_seq[s];
                            e_rp[t] = b_pc[s] + ISZ; e_rt[t] = 0;
                            cut = b_seq[s]; dead = 1;
                        end else if (isdir && b_ct[s] != b_pt[s]) begin
                            bit tk = (b_ct[s] != b_pc[s] + ISZ);
                            m_cmiss++;
                            if (ds && !(b_ptk[s] && b_cds[s])) begin
                                m_pv[t] = 1; m_ps[t] = b_seq[s] + 16'd1; m_pp[t] = b_ct[s]; m_ptk[t] = tk;
                            end else begin
                                e_rv[t] = 1; e_rm[t] = 1; e_rs[t] = b_seq[s]; e_rp[t] = b_ct[s]; e_rt[t] = tk;
                                cut = b_seq[s]; dead = 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    // called at a falling edge; returns at the falling edge after the result is registered
    task automatic run_cycle(input string tag);
        apply();
        model_step(dslot_mode);
        @(posedge clk);
        @(negedge clk);
        chk(out_vld == e_vld, tag, "slot valid (R3 latency)", 32'(out_vld), 32'(e_vld));
        chk(out_squashed == e_sq, tag, "squash mask (R5)", 32'(out_squashed), 32'(e_sq));
        chk(out_issue_rdy == e_rdy, tag, "issue ready (R9)", 32'(out_issue_rdy), 32'(e_rdy));
        for (int t = 0; t < T; t++) begin
            chk(redir_vld[t] == e_rv[t], tag, $sformatf("redirect valid t%0d (R10)", t),
                32'(redir_vld[t]), 32'(e_rv[t]));
            if (e_rv[t] && redir_vld[t]) begin
                chk(redir_seq[t*SEQW +: SEQW] == e_rs[t], tag, "redirect seq (R6/R7)",
                    32'(redir_seq[t*SEQW +: SEQW]), 32'(e_rs[t]));
                chk(redir_pc[t*PCW +: PCW] == e_rp[t], tag, "redirect pc (R3/R8)",
                    redir_pc[t*PCW +: PCW], e_rp[t]);
                chk(redir_taken[t] == e_rt[t], tag, "redirect taken (R4)",
                    32'(redir_taken[t]), 32'(e_rt[t]));
                chk(redir_tgt_miss[t] == e_rm[t], tag, "redirect kind (R8)",
                    32'(redir_tgt_miss[t]), 32'(e_rm[t]));
            end
        end
        chk(cnt_resolved == CNTW'(m_cdir), tag, "resolved count (R2)", 32'(cnt_resolved), 32'(m_cdir));
        chk(cnt_tgt_miss == CNTW'(m_cmiss), tag, "mismatch count (R3)", 32'(cnt_tgt_miss), 32'(m_cmiss));
        chk(cnt_ctrl_miss == CNTW'(m_cfake), tag, "false control count (R8)", 32'(cnt_ctrl_miss), 32'(m_cfake));
    endtask

    task automatic rand_bundle();
        clear_slots();
        for (int s = 0; s < W; s++) begin
            if ($urandom % 5 != 0) begin
                int k = $urandom % 8;
                int kind = (k < 4) ? 1 : (k == 4) ? 2 : (k == 5) ? 3 : 0;
                bit ptk = (kind != 0) ? bit'($urandom % 2) : bit'($urandom % 6 == 0);
                logic [31:0] coff = ($urandom % 3 == 0) ? 32'd4 : 32'(32 * ($urandom % 4 + 1));
                mk(s, $urandom % T, kind, ptk, bit'($urandom % 2), coff, bit'($urandom % 3 == 0), $urandom % 4);
            end
        end
    endtask

    task automatic drain();
        clear_slots();
        mk(0, 0, 0, 0, 0, 32'd4, 0, 1);
        mk(1, 1, 0, 0, 0, 32'd4, 0, 1);
        run_cycle("R7 drain");
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);
        for (int t = 0; t < T; t++) begin m_pv[t] = 0; m_ptk[t] = 0; m_ps[t] = '0; m_pp[t] = '0; end
        clear_slots();
        apply();
        repeat (3) @(posedge clk);
        // R1: outputs cleared while reset held
        @(negedge clk);
        chk(out_vld == '0 && out_squashed == '0 && out_issue_rdy == '0, "R1", "slot outputs in reset",
            32'({out_vld, out_squashed, out_issue_rdy}), 32'd0);
        chk(redir_vld == '0 && cnt_resolved == '0 && cnt_tgt_miss == '0 && cnt_ctrl_miss == '0,
            "R1", "redirect and counters in reset", 32'(redir_vld), 32'd0);
        rst_n = 1'b1;
        run_cycle("R1 idle after reset");

        // R3/R4/R5: mismatch, not taken flow, younger same-thread squashed, other thread kept
        clear_slots();
        mk(0, 0, 0, 0, 0, 32'd4, 0, 0);
        mk(1, 0, 1, 0, 0, 32'd4, 1, 1);
        mk(2, 1, 0, 0, 0, 32'd4, 0, 2);
        mk(3, 0, 0, 0, 0, 32'd4, 0, 0);
        run_cycle("R3 R4 R5 mismatch fallthrough");
        clear_slots();
        mk(0, 1, 1, 1, 0, 32'd96, 1, 1);
        mk(1, 1, 3, 1, 0, 32'd64, 0, 1);
        mk(2, 0, 2, 1, 0, 32'd64, 1, 1);
        run_cycle("R4 R2 taken target");
        // R10: two mismatches in one thread, oldest wins
        clear_slots();
        mk(0, 0, 1, 1, 0, 32'd32, 1, 1);
        mk(1, 0, 1, 1, 0, 32'd64, 1, 1);
        mk(2, 1, 1, 1, 0, 32'd32, 1, 3);
        mk(3, 1, 0, 1, 0, 32'd4, 0, 0);
        run_cycle("R10 oldest wins");
        // R8: false control
        clear_slots();
        mk(0, 0, 1, 1, 0, 32'd32, 0, 1);
        mk(1, 0, 0, 1, 0, 32'd4, 0, 1);
        mk(2, 0, 1, 1, 0, 32'd32, 1, 1);
        run_cycle("R8 false control");

        // delay-slot mode
        dslot_mode = 1'b1;
        clear_slots();
        mk(0, 0, 1, 1, 1, 32'd48, 1, 1);
        mk(1, 0, 0, 0, 0, 32'd4, 0, 1);
        mk(2, 1, 1, 0, 1, 32'd48, 1, 1);
        mk(3, 1, 0, 0, 0, 32'd4, 0, 0);
        run_cycle("R6 R7 immediate vs deferred in bundle");
        clear_slots();
        mk(0, 0, 0, 0, 0, 32'd4, 0, 1);
        mk(3, 0, 1, 1, 0, 32'd80, 1, 1);
        run_cycle("R7 defer at last slot");
        clear_slots();
        mk(0, 0, 1, 1, 0, 32'd16, 1, 1);
        mk(1, 1, 0, 0, 0, 32'd4, 0, 1);
        mk(2, 0, 0, 1, 0, 32'd4, 0, 1);
        mk(3, 0, 1, 0, 0, 32'd4, 0, 0);
        run_cycle("R11 R7 delay slot next bundle");
        drain();

        for (int i = 0; i < 600; i++) begin rand_bundle(); run_cycle("R5 R10 random plain"); end
        drain();
        dslot_mode = 1'b0;
        drain();
        for (int i = 0; i < 600; i++) begin rand_bundle(); run_cycle("R2 R3 random"); end
        dslot_mode = 1'b1;
        for (int i = 0; i < 600; i++) begin rand_bundle(); run_cycle("R7 R11 random delay"); end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual %0d cycles expected completion earlier", 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule